// File: doc/BRIEF.md
# Half-Bridge and PFC Gate Protection Controller

This block sits between a motor controller's PWM generator and the gate enables of a three-phase inverter plus one power-factor-correction switch. It passes the seven PWM commands through to seven registered gate enables. It removes them whenever driving them would be unsafe. It also produces an active-low fault indication for the controller.

All inputs are asynchronous digital flags and are brought into the clock domain by two-flop synchronizers. The analog comparators that produce these flags sit outside the block. Each command is then filtered so that pulses shorter than a minimum width are dropped. After filtering, each command is gated by several conditions:
- a per-phase shoot-through interlock,
- the supply and per-phase bias undervoltage flags,
- the external enable,
- a latched overcurrent trip.

An overcurrent flag from either the inverter or the PFC comparator must stay high through a blanking window before it is accepted. Once accepted, it produces a fault pulse of fixed length that ends by itself. The gates stay off until that pulse has ended and the overcurrent flag has also dropped. After reset, and after every supply undervoltage, each high-side gate stays locked out until its own phase's low-side command has been seen.

Top module: `gate_guard`

## Requirements
- R1: If a phase's filtered high-side and low-side commands are both high, both gates of that phase are held low.
- R2: While supply undervoltage `vdd_uv_i` is high, all seven gates are low. Gates whose start-up lockout (R4) is clear return to following their commands once the flag drops.
- R3: A bias undervoltage flag `bias_uv_i[k]` forces only `hi_gate_o[k]` low. Every other gate is unaffected, and `hi_gate_o[k]` recovers when the flag drops.
- R4: After reset and after each supply undervoltage, `hi_gate_o[k]` stays low until `lo_cmd_i[k]` has been seen high after filtering.
- R5: An overcurrent flag that is high for fewer than BLANK_CYC consecutive synchronized cycles causes no fault and leaves the gates unchanged.
- R6: An overcurrent flag from either source that is held for at least BLANK_CYC cycles forces all seven gates low and drives `fault_no` low.
- R7: The overcurrent fault pulse on `fault_no` lasts exactly FAULT_CYC cycles, even if the flag persists. The gates stay low until the pulse has ended and the flag has dropped.
- R8: `fault_no` is low for the whole time `vdd_uv_i` is high.
- R9: While `en_i` is low, all seven gates are low and `fault_no` stays high. Raising `en_i` restores normal driving.
- R10: A command pulse, high or low, shorter than MIN_PULSE cycles does not reach the gates. A longer change appears on the gate MIN_PULSE+3 cycles after the input changes.
- R11: During reset all gates are low, `fault_no` is high and every high-side lockout is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cmd_i | input | 3 | High-side PWM commands, bit k = phase k |
| lo_cmd_i | input | 3 | Low-side PWM commands, bit k = phase k |
| pfc_cmd_i | input | 1 | PFC switch PWM command |
| oc_inv_i | input | 1 | Inverter overcurrent comparator flag |
| oc_pfc_i | input | 1 | PFC overcurrent comparator flag |
| vdd_uv_i | input | 1 | Supply undervoltage flag |
| bias_uv_i | input | 3 | Per-phase high-side bias undervoltage flags |
| en_i | input | 1 | External driver enable, active high |
| hi_gate_o | output | 3 | High-side gate enables |
| lo_gate_o | output | 3 | Low-side gate enables |
| pfc_gate_o | output | 1 | PFC gate enable |
| fault_no | output | 1 | Fault indication, active low |

## Verification
The hardest state to reach is an overcurrent that outlasts its own fault pulse. In that state `fault_no` has already returned high while the gates must stay low. The bench holds the PFC flag high and measures the pulse length cycle by cycle. It confirms the gates are still low after the pulse ends, then drops the flag and checks that the previous gate pattern returns. Re-arming the high-side lockout also takes a specific sequence. The bench applies undervoltage while a high-side command is held, checks that the gate stays dark once undervoltage clears, and releases it only after a low-side pulse.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int unsigned NPH = 3;
  // synchronized input bus layout
  localparam int unsigned CMD_W = 2 * NPH + 1;
  localparam int unsigned SYNC_W = CMD_W + 3 + NPH + 1;
  typedef struct packed {
    logic           en;
    logic [NPH-1:0] bias_uv;
    logic           vdd_uv;
    logic           oc_pfc;
    logic           oc_inv;
    logic           pfc;
    logic [NPH-1:0] lo;
    logic [NPH-1:0] hi;
  } sync_bus_t;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gp_pulse_filter.sv
module gp_pulse_filter #(
  parameter int unsigned W         = 1,
  parameter int unsigned MIN_PULSE = 100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = $clog2(MIN_PULSE + 1);

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (MIN_PULSE <= 1) begin : g_pass
      logic q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= 1'b0;
        else         q_r <= d_i[g];
      end
      assign q_o[g] = q_r;
    end else begin : g_cnt
      logic          q_r;
      logic [CW-1:0] cnt_q;
      // new level must hold MIN_PULSE consecutive cycles
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_r   <= 1'b0;
          cnt_q <= '0;
        end else if (d_i[g] == q_r) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(MIN_PULSE - 1)) begin
          q_r   <= d_i[g];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign q_o[g] = q_r;
    end
  end
endmodule

// File: rtl/gp_oc_guard.sv
module gp_oc_guard #(
  parameter int unsigned BLANK_CYC = 35,
  parameter int unsigned FAULT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_inv_i,
  input  logic oc_pfc_i,
  output logic trip_o,
  output logic pulse_o
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam int unsigned FW = $clog2(FAULT_CYC + 1);

  logic          oc_any;
  logic          accept;
  logic [BW-1:0] blk_q;
  logic [FW-1:0] fcnt_q;
  logic          trip_q, fon_q;

  assign oc_any = oc_inv_i | oc_pfc_i;
  assign accept = oc_any && !trip_q && (blk_q == BW'(BLANK_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         blk_q <= '0;
    else if (!oc_any)                    blk_q <= '0;
    else if (blk_q != BW'(BLANK_CYC))    blk_q <= blk_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      fon_q  <= 1'b0;
      fcnt_q <= '0;
    end else if (accept) begin
      trip_q <= 1'b1;
      fon_q  <= 1'b1;
      fcnt_q <= FW'(FAULT_CYC - 1);
    end else begin
      if (fon_q) begin
        if (fcnt_q == '0) fon_q  <= 1'b0;
        else              fcnt_q <= fcnt_q - 1'b1;
      end
      // gates held until pulse done and flag gone
      if (trip_q && !fon_q && !oc_any) trip_q <= 1'b0;
    end
  end

  assign trip_o  = trip_q;
  assign pulse_o = fon_q;

  // R6
  trip_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_q) |-> $past(oc_any));
  // R7
  pulse_in_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fon_q |-> trip_q);
  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip_q) |-> !$past(oc_any) && !$past(fon_q));
endmodule

// File: rtl/gp_phase.sv
module gp_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic lo_i,
  input  logic kill_i,
  input  logic uv_i,
  input  logic bias_uv_i,
  output logic hi_o,
  output logic lo_o
);
  logic arm_q, hi_q, lo_q;

  // high side locked out until a low-side command is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   arm_q <= 1'b1;
    else if (uv_i) arm_q <= 1'b1;
    else if (lo_i) arm_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_i && !lo_i && !kill_i && !bias_uv_i && !arm_q;
      lo_q <= lo_i && !hi_i && !kill_i;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R1
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q));
  // R2
  uv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> !hi_q && !lo_q);
  // R3
  bias_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_uv_i |=> !hi_q);
  // R4
  lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |=> !hi_q);
endmodule

// File: rtl/gate_guard.sv
module gate_guard
  import gp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PULSE   = 100,
  parameter int unsigned BLANK_CYC   = 35,
  parameter int unsigned FAULT_CYC   = 200
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] hi_cmd_i,
  input  logic [NPH-1:0] lo_cmd_i,
  input  logic           pfc_cmd_i,
  input  logic           oc_inv_i,
  input  logic           oc_pfc_i,
  input  logic           vdd_uv_i,
  input  logic [NPH-1:0] bias_uv_i,
  input  logic           en_i,
  output logic [NPH-1:0] hi_gate_o,
  output logic [NPH-1:0] lo_gate_o,
  output logic           pfc_gate_o,
  output logic           fault_no
);
  sync_bus_t        raw, syn;
  logic [CMD_W-1:0] cmd_f;
  logic             trip, pulse, kill;
  logic             pfc_q, fault_nq;

  assign raw = '{en: en_i, bias_uv: bias_uv_i, vdd_uv: vdd_uv_i, oc_pfc: oc_pfc_i,
                 oc_inv: oc_inv_i, pfc: pfc_cmd_i, lo: lo_cmd_i, hi: hi_cmd_i};

  gp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  gp_pulse_filter #(.W(CMD_W), .MIN_PULSE(MIN_PULSE)) u_filt (
    .clk_i, .rst_ni, .d_i({syn.pfc, syn.lo, syn.hi}), .q_o(cmd_f)
  );

  gp_oc_guard #(.BLANK_CYC(BLANK_CYC), .FAULT_CYC(FAULT_CYC)) u_oc (
    .clk_i, .rst_ni, .oc_inv_i(syn.oc_inv), .oc_pfc_i(syn.oc_pfc),
    .trip_o(trip), .pulse_o(pulse)
  );

  assign kill = syn.vdd_uv | trip | ~syn.en;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    gp_phase u_ph (
      .clk_i, .rst_ni,
      .hi_i(cmd_f[k]), .lo_i(cmd_f[NPH+k]),
      .kill_i(kill), .uv_i(syn.vdd_uv), .bias_uv_i(syn.bias_uv[k]),
      .hi_o(hi_gate_o[k]), .lo_o(lo_gate_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pfc_q    <= 1'b0;
      fault_nq <= 1'b1;
    end else begin
      pfc_q    <= cmd_f[CMD_W-1] && !kill;
      fault_nq <= !(pulse || syn.vdd_uv);
    end
  end

  assign pfc_gate_o = pfc_q;
  assign fault_no   = fault_nq;

  // R9
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn.en |=> (hi_gate_o == '0) && (lo_gate_o == '0) && !pfc_gate_o);
  // R8
  uv_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn.vdd_uv |=> !fault_no);
  // R6
  trip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip |=> !pfc_gate_o && (lo_gate_o == '0));
endmodule

// File: tb/gate_guard_tb_top.sv
module gate_guard_tb_top;
  localparam int MINP  = 4;
  localparam int BLANK = 6;
  localparam int FLEN  = 20;
  localparam int SETTLE = MINP + 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi_cmd = '0, lo_cmd = '0, bias_uv = '0;
  logic       pfc_cmd = 1'b0, oc_inv = 1'b0, oc_pfc = 1'b0, vdd_uv = 1'b0, en = 1'b0;
  logic [2:0] hi_gate, lo_gate;
  logic       pfc_gate, fault_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] v;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  gate_guard #(.MIN_PULSE(MINP), .BLANK_CYC(BLANK), .FAULT_CYC(FLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hi_cmd_i(hi_cmd), .lo_cmd_i(lo_cmd),
    .pfc_cmd_i(pfc_cmd), .oc_inv_i(oc_inv), .oc_pfc_i(oc_pfc), .vdd_uv_i(vdd_uv),
    .bias_uv_i(bias_uv), .en_i(en), .hi_gate_o(hi_gate), .lo_gate_o(lo_gate),
    .pfc_gate_o(pfc_gate), .fault_no(fault_n)
  );

  function automatic logic [7:0] outs();
    return {fault_n, pfc_gate, lo_gate, hi_gate};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, outs(), e.v);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_v(string tag, logic fno, logic pfc, logic [2:0] lo, logic [2:0] hi);
    exp_t e;
    e.tag = tag;
    e.v = {fno, pfc, lo, hi};
    sb_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    bit seen;
    step(3);
    expect_v("R11 reset state", 1'b1, 1'b0, 3'b000, 3'b000);
    rst_n = 1'b1;
    en = 1'b1;
    hi_cmd = 3'b001;
    pfc_cmd = 1'b1;
    step(SETTLE);
    expect_v("R4 lockout after reset", 1'b1, 1'b1, 3'b000, 3'b000);

    // clear lockout on every phase
    hi_cmd = 3'b000;
    lo_cmd = 3'b111;
    step(SETTLE);
    expect_v("R4 low side drives", 1'b1, 1'b1, 3'b111, 3'b000);
    lo_cmd = 3'b000;
    hi_cmd = 3'b001;
    step(SETTLE);
    expect_v("R4 high side released", 1'b1, 1'b1, 3'b000, 3'b001);

    // R1 interlock
    hi_cmd = 3'b011;
    lo_cmd = 3'b010;
    step(SETTLE);
    expect_v("R1 both commands", 1'b1, 1'b1, 3'b000, 3'b001);
    hi_cmd = 3'b001;
    step(SETTLE);
    expect_v("R1 low only", 1'b1, 1'b1, 3'b010, 3'b001);

    // R10 short pulse dropped, long pulse latency
    lo_cmd[2] = 1'b1;
    step(MINP - 1);
    lo_cmd[2] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 15; i++) begin
      step(1);
      if (lo_gate[2]) seen = 1'b1;
    end
    chk("R10 short pulse ignored", {7'b0, seen}, 8'd0);
    lo_cmd[2] = 1'b1;
    step(MINP + 2);
    expect_v("R10 before latency", 1'b1, 1'b1, 3'b010, 3'b001);
    step(1);
    expect_v("R10 at latency", 1'b1, 1'b1, 3'b110, 3'b001);
    lo_cmd[2] = 1'b0;
    step(SETTLE);

    // R3 bias undervoltage on phase 0
    bias_uv = 3'b001;
    step(SETTLE);
    expect_v("R3 bias off", 1'b1, 1'b1, 3'b010, 3'b000);
    bias_uv = 3'b000;
    step(SETTLE);
    expect_v("R3 bias recover", 1'b1, 1'b1, 3'b010, 3'b001);

    // R9 enable
    en = 1'b0;
    step(SETTLE);
    expect_v("R9 disabled", 1'b1, 1'b0, 3'b000, 3'b000);
    en = 1'b1;
    step(SETTLE);
    expect_v("R9 re-enabled", 1'b1, 1'b1, 3'b010, 3'b001);

    // R5 short overcurrent
    oc_inv = 1'b1;
    step(BLANK - 2);
    oc_inv = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (!fault_n || outs() != 8'b1101_0001) seen = 1'b1;
    end
    chk("R5 blanked", {7'b0, seen}, 8'd0);

    // R6 R7 persistent PFC overcurrent
    oc_pfc = 1'b1;
    cnt = 0;
    while (fault_n && cnt < 40) begin step(1); cnt++; end
    expect_v("R6 pfc trip", 1'b0, 1'b0, 3'b000, 3'b000);
    cnt = 0;
    while (!fault_n && cnt < 100) begin
      @(negedge clk);
      cnt++;
      #1;
    end
    chk("R7 pulse length", 8'(cnt), 8'(FLEN));
    step(5);
    expect_v("R7 held while flag high", 1'b1, 1'b0, 3'b000, 3'b000);
    oc_pfc = 1'b0;
    step(SETTLE);
    expect_v("R7 resume", 1'b1, 1'b1, 3'b010, 3'b001);

    // R6 inverter source
    oc_inv = 1'b1;
    step(BLANK + 4);
    oc_inv = 1'b0;
    cnt = 0;
    while (fault_n && cnt < 40) begin step(1); cnt++; end
    expect_v("R6 inverter trip", 1'b0, 1'b0, 3'b000, 3'b000);
    step(FLEN + 10);
    expect_v("R6 inverter recover", 1'b1, 1'b1, 3'b010, 3'b001);

    // R2 R8 supply undervoltage, R4 re-lock
    vdd_uv = 1'b1;
    step(SETTLE);
    expect_v("R2 uv gates off", 1'b0, 1'b0, 3'b000, 3'b000);
    step(FLEN + 10);
    expect_v("R8 fault for whole uv", 1'b0, 1'b0, 3'b000, 3'b000);
    vdd_uv = 1'b0;
    step(SETTLE);
    expect_v("R4 relocked after uv", 1'b1, 1'b1, 3'b010, 3'b000);
    hi_cmd = 3'b000;
    lo_cmd = 3'b011;
    step(SETTLE);
    lo_cmd = 3'b010;
    hi_cmd = 3'b001;
    step(SETTLE);
    expect_v("R2 resume after low pulse", 1'b1, 1'b1, 3'b010, 3'b001);

    step(2);
    finish_run();
  end
endmodule